// File: doc/BRIEF.md
# 16-bit ModRM Effective Offset Generator

This block turns a ModRM byte into the 16-bit effective offset of a memory operand under the legacy 16-bit addressing forms. A request is accepted with a valid/ready handshake. It carries the ModRM byte, an optional segment override, a flat-mode flag and the write bit. The block then pulls the displacement bytes that the form needs, zero, one or two, from a byte stream. Each byte moves on the cycle in which both its valid and its ready are high.

The general registers bx, bp, si and di come in on a register port. The block adds the register pair selected by the rm field to the displacement and keeps only the low 16 bits. It raises a one-cycle result strobe that carries the offset, the segment to use, whether that segment came from an override, the number of displacement bytes consumed, and two fault flags. Segment translation and limit checking belong to later stages.

Top module: `modrm16_agen`

## Requirements
- R1: The start handshake and the result strobe work as follows. `startReady` is high only while the block is idle. A request is accepted on a clock edge where `startValid` and `startReady` are both high. `doneValid` is high for exactly one cycle per request, and `startReady` is high again in the cycle after that.
- R2: The number of displacement bytes depends on the mod field (ModRM bits 7:6) and the rm field (ModRM bits 2:0). With mod 0 it is zero bytes, except two bytes when rm is 6. Mod 1 takes one byte, mod 2 takes two bytes and mod 3 takes none. `dispReady` is high only while bytes are still owed. `bytesUsed` reports the count while `doneValid` is high.
- R3: A two-byte displacement arrives low byte first.
- R4: The rm values 0 through 7 add bx+si, bx+di, bp+si, bp+di, si, di, bp and bx, in that order.
- R5: With mod 1, the single displacement byte is sign-extended to 16 bits before it is added.
- R6: With mod 0 and rm 6, the offset is the two-byte displacement alone, with no register term.
- R7: The offset is the sum taken modulo 65536.
- R8: `segCode` uses the codes es=0, cs=1, ss=2, ds=3, fs=4, gs=5. When an override is present, the override code is output and `segOverridden`=1. Otherwise the segment is ss for the bp-based forms, meaning rm 2, 3 or 6 except mod 0 with rm 6, and ds for all other forms, with `segOverridden`=0.
- R9: Mod 3 sets `invalid`=1, outputs offset 0 and consumes no displacement bytes. Every other mod gives `invalid`=0.
- R10: `writeFault`=1 exactly when `flatMode` is set, ModRM bit 4 is set, and a cs override (code 1) is present.
- R11: After reset, `startReady`=1, `dispReady`=0 and `doneValid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startValid | input | 1 | A request is offered |
| startReady | output | 1 | The block can accept a request |
| modrm | input | 8 | ModRM byte of the request |
| ovrValid | input | 1 | A segment override applies to the request |
| ovrSeg | input | 3 | Code of the override segment |
| flatMode | input | 1 | Flat addressing mode is in effect |
| dispValid | input | 1 | A displacement byte is offered |
| dispReady | output | 1 | The block wants a displacement byte |
| dispByte | input | 8 | Displacement byte |
| regBx | input | 16 | Value of bx |
| regBp | input | 16 | Value of bp |
| regSi | input | 16 | Value of si |
| regDi | input | 16 | Value of di |
| doneValid | output | 1 | Result strobe, high for one cycle |
| offset | output | 16 | Effective offset |
| segCode | output | 3 | Segment to apply |
| segOverridden | output | 1 | The segment came from an override |
| bytesUsed | output | 2 | Displacement bytes consumed |
| invalid | output | 1 | The form is not a memory operand |
| writeFault | output | 1 | A write through cs in flat mode |

## Verification
Several functions can fall in the same result cycle. The ss default of a bp-based form can meet an override, which must win. The invalid flag can meet a write fault when a mod 3 form carries the write bit and a cs override in flat mode. The bench sweeps every mod and rm pair with overrides and the write bit turned on in combination, so these collisions come up. It also inserts idle gaps in the displacement stream, so that the byte count and the strobe position are checked cycle by cycle against a behavioural model.

// File: rtl/agen16_pkg.sv
package agen16_pkg;
  localparam logic [2:0] SEG_ES = 3'd0;
  localparam logic [2:0] SEG_CS = 3'd1;
  localparam logic [2:0] SEG_SS = 3'd2;
  localparam logic [2:0] SEG_DS = 3'd3;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_DONE} agenState_t;

  typedef struct packed {
    logic load;
    logic capLo;
    logic capHi;
  } ctlStrobes_t;
endpackage

// File: rtl/agen16_ctl.sv
module agen16_ctl
  import agen16_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startValid,
  input  logic [1:0]  modIn,
  input  logic [2:0]  rmIn,
  input  logic        dispValid,
  output logic        startReady,
  output logic        dispReady,
  output logic        doneValid,
  output logic [1:0]  bytesUsed,
  output ctlStrobes_t strb
);
  agenState_t state;
  logic [1:0] needQ;
  logic [1:0] gotQ;
  logic [1:0] needNow;
  logic       accept;
  logic       take;

  always_comb begin
    unique case (modIn)
      2'd0:    needNow = (rmIn == 3'd6) ? 2'd2 : 2'd0;
      2'd1:    needNow = 2'd1;
      2'd2:    needNow = 2'd2;
      default: needNow = 2'd0;
    endcase
  end

  assign startReady = (state == ST_IDLE);
  assign dispReady  = (state == ST_FETCH);
  assign doneValid  = (state == ST_DONE);
  assign bytesUsed  = gotQ;
  assign accept     = startValid && startReady;
  assign take       = dispValid && dispReady;

  always_comb begin
    strb.load  = accept;
    strb.capLo = take && (gotQ == 2'd0);
    strb.capHi = take && (gotQ == 2'd1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      needQ <= 2'd0;
      gotQ  <= 2'd0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          needQ <= needNow;
          gotQ  <= 2'd0;
          state <= (needNow == 2'd0) ? ST_DONE : ST_FETCH;
        end
        ST_FETCH: if (take) begin
          gotQ <= gotQ + 2'd1;
          if (gotQ + 2'd1 == needQ) state <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_ready_excl_r1: assert property (@(posedge clk) disable iff (!rstN)
    !(startReady && dispReady));
  p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> (!doneValid && startReady));
  p_fetch_wait_r2: assert property (@(posedge clk) disable iff (!rstN)
    (dispReady && !dispValid) |=> dispReady);
endmodule

// File: rtl/agen16_dp.sv
module agen16_dp
  import agen16_pkg::*;
#(
  parameter int OFFS_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strb,
  input  logic [1:0]        modIn,
  input  logic [2:0]        rmIn,
  input  logic              wrIn,
  input  logic              ovrValidIn,
  input  logic [2:0]        ovrSegIn,
  input  logic              flatIn,
  input  logic [7:0]        dispByte,
  input  logic [OFFS_W-1:0] regBx,
  input  logic [OFFS_W-1:0] regBp,
  input  logic [OFFS_W-1:0] regSi,
  input  logic [OFFS_W-1:0] regDi,
  output logic [OFFS_W-1:0] offset,
  output logic [2:0]        segCode,
  output logic              segOverridden,
  output logic              invalid,
  output logic              writeFault
);
  localparam int HI_W = OFFS_W - 8;

  logic [1:0]        modQ;
  logic [2:0]        rmQ;
  logic              wrQ, ovrQ, flatQ;
  logic [2:0]        ovrSegQ;
  logic [7:0]        loQ, hiQ;
  logic [OFFS_W-1:0] baseTerm, indexTerm, dispTerm;
  logic              dispOnly, bpForm;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modQ <= '0; rmQ <= '0; wrQ <= 1'b0; ovrQ <= 1'b0;
      flatQ <= 1'b0; ovrSegQ <= '0; loQ <= '0; hiQ <= '0;
    end else begin
      if (strb.load) begin
        modQ <= modIn; rmQ <= rmIn; wrQ <= wrIn; ovrQ <= ovrValidIn;
        flatQ <= flatIn; ovrSegQ <= ovrSegIn; loQ <= '0; hiQ <= '0;
      end
      if (strb.capLo) loQ <= dispByte;
      if (strb.capHi) hiQ <= dispByte;
    end
  end

  assign dispOnly = (modQ == 2'd0) && (rmQ == 3'd6);
  assign bpForm   = ((rmQ == 3'd2) || (rmQ == 3'd3) || (rmQ == 3'd6)) && !dispOnly;

  always_comb begin
    unique case (rmQ)
      3'd0, 3'd1, 3'd7: baseTerm = regBx;
      3'd2, 3'd3, 3'd6: baseTerm = regBp;
      default:          baseTerm = '0;
    endcase
    unique case (rmQ)
      3'd0, 3'd2, 3'd4: indexTerm = regSi;
      3'd1, 3'd3, 3'd5: indexTerm = regDi;
      default:          indexTerm = '0;
    endcase
    unique case (modQ)
      2'd1:    dispTerm = {{HI_W{loQ[7]}}, loQ};
      2'd2:    dispTerm = {{(HI_W-8){1'b0}}, hiQ, loQ};
      2'd0:    dispTerm = dispOnly ? {{(HI_W-8){1'b0}}, hiQ, loQ} : '0;
      default: dispTerm = '0;
    endcase
  end

  always_comb begin
    invalid = (modQ == 2'd3);
    if (invalid)       offset = '0;
    else if (dispOnly) offset = dispTerm;
    else               offset = baseTerm + indexTerm + dispTerm;
    segOverridden = ovrQ;
    segCode       = ovrQ ? ovrSegQ : (bpForm ? SEG_SS : SEG_DS);
    writeFault    = flatQ && wrQ && ovrQ && (ovrSegQ == SEG_CS);
  end

  p_load_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(segOverridden));
endmodule

// File: rtl/modrm16_agen.sv
module modrm16_agen
  import agen16_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startValid,
  output logic        startReady,
  input  logic [7:0]  modrm,
  input  logic        ovrValid,
  input  logic [2:0]  ovrSeg,
  input  logic        flatMode,
  input  logic        dispValid,
  output logic        dispReady,
  input  logic [7:0]  dispByte,
  input  logic [15:0] regBx,
  input  logic [15:0] regBp,
  input  logic [15:0] regSi,
  input  logic [15:0] regDi,
  output logic        doneValid,
  output logic [15:0] offset,
  output logic [2:0]  segCode,
  output logic        segOverridden,
  output logic [1:0]  bytesUsed,
  output logic        invalid,
  output logic        writeFault
);
  ctlStrobes_t strb;

  agen16_ctl u_ctl (
    .clk(clk), .rstN(rstN), .startValid(startValid),
    .modIn(modrm[7:6]), .rmIn(modrm[2:0]), .dispValid(dispValid),
    .startReady(startReady), .dispReady(dispReady), .doneValid(doneValid),
    .bytesUsed(bytesUsed), .strb(strb)
  );

  agen16_dp #(.OFFS_W(16)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .modIn(modrm[7:6]), .rmIn(modrm[2:0]), .wrIn(modrm[4]),
    .ovrValidIn(ovrValid), .ovrSegIn(ovrSeg), .flatIn(flatMode),
    .dispByte(dispByte), .regBx(regBx), .regBp(regBp), .regSi(regSi),
    .regDi(regDi), .offset(offset), .segCode(segCode),
    .segOverridden(segOverridden), .invalid(invalid), .writeFault(writeFault)
  );

  p_mod3_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && invalid) |-> (bytesUsed == 2'd0 && offset == 16'd0));
  p_fault_seg_r10: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && writeFault) |-> (segOverridden && segCode == SEG_CS));
endmodule

// File: tb/test_modrm16_agen.sv
module test_modrm16_agen;
  logic clk = 1'b0, rstN = 1'b0;
  logic startValid = 1'b0, ovrValid = 1'b0, flatMode = 1'b0, dispValid = 1'b0;
  logic [7:0] modrm = '0, dispByte = '0;
  logic [2:0] ovrSeg = '0;
  logic [15:0] regBx = '0, regBp = '0, regSi = '0, regDi = '0;
  logic startReady, dispReady, doneValid, segOverridden, invalid, writeFault;
  logic [15:0] offset;
  logic [2:0] segCode;
  logic [1:0] bytesUsed;

  int nRun = 0, nFail = 0, cyc = 0;
  bit finished = 0;

  // behavioural model state
  int mPhase = 0, mNeed = 0, mGot = 0;
  int mMod = 0, mRm = 0, mWr = 0, mOvr = 0, mSeg = 0, mFlat = 0;
  byte unsigned mBytes[$];

  always #4 clk = ~clk;

  modrm16_agen i_modrm16_agen (.*);

  function automatic int needOf(int md, int r);
    if (md == 0) return (r == 6) ? 2 : 0;
    if (md == 1) return 1;
    if (md == 2) return 2;
    return 0;
  endfunction

  task automatic check(string tag, int act, int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // model advance on each edge, from inputs held since the last falling edge
  always @(posedge clk) begin
    if (!rstN) begin
      mPhase <= 0;
    end else begin
      case (mPhase)
        0: if (startValid) begin
          mMod <= int'(modrm[7:6]); mRm <= int'(modrm[2:0]); mWr <= int'(modrm[4]);
          mOvr <= int'(ovrValid); mSeg <= int'(ovrSeg); mFlat <= int'(flatMode);
          mNeed <= needOf(modrm[7:6], modrm[2:0]); mGot <= 0; mBytes.delete();
          mPhase <= (needOf(modrm[7:6], modrm[2:0]) == 0) ? 2 : 1;
        end
        1: if (dispValid) begin
          mBytes.push_back(dispByte);
          mGot <= mGot + 1;
          if (mGot + 1 == mNeed) mPhase <= 2;
        end
        default: mPhase <= 0;
      endcase
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      check("R1 startReady", int'(startReady), int'(mPhase == 0));
      check("R2 dispReady", int'(dispReady), int'(mPhase == 1));
      check("R1 doneValid", int'(doneValid), int'(mPhase == 2));
      if (mPhase == 2) begin
        int disp, sum, eSeg, bpF, dOnly;
        dOnly = (mMod == 0 && mRm == 6);
        disp = 0;
        if (mMod == 1) disp = int'(byte'(mBytes[0]));           // R5
        else if (mMod == 2 || dOnly) disp = mBytes[0] + 256 * mBytes[1]; // R3
        case (mRm)                                              // R4
          0: sum = regBx + regSi;  1: sum = regBx + regDi;
          2: sum = regBp + regSi;  3: sum = regBp + regDi;
          4: sum = regSi;          5: sum = regDi;
          6: sum = dOnly ? 0 : regBp;                           // R6
          default: sum = regBx;
        endcase
        sum = (sum + disp) & 32'hFFFF;                          // R7
        if (mMod == 3) sum = 0;
        bpF = (mRm == 2 || mRm == 3 || mRm == 6) && !dOnly;
        eSeg = mOvr ? mSeg : (bpF ? 2 : 3);
        check("R3/R4/R5/R6/R7/R9 offset", int'(offset), sum);
        check("R8 segCode", int'(segCode), eSeg);
        check("R8 segOverridden", int'(segOverridden), mOvr);
        check("R2/R9 bytesUsed", int'(bytesUsed), mNeed);
        check("R9 invalid", int'(invalid), int'(mMod == 3));
        check("R10 writeFault", int'(writeFault), int'(mFlat && mWr && mOvr && mSeg == 1));
      end
    end
  end

  task automatic runOp(logic [7:0] m, logic ov, logic [2:0] sg, logic fl,
                       logic [7:0] b0, logic [7:0] b1, bit gaps);
    int idx = 0;
    int guard = 0;
    @(negedge clk);
    while (!startReady) @(negedge clk);
    modrm = m; ovrValid = ov; ovrSeg = sg; flatMode = fl; startValid = 1'b1;
    @(negedge clk);
    startValid = 1'b0;
    while (!doneValid && guard < 20) begin
      dispValid = (idx < 2) && !(gaps && guard[0]);
      dispByte = (idx == 0) ? b0 : b1;
      if (dispValid && dispReady) idx++;
      guard++;
      @(negedge clk);
    end
    dispValid = 1'b0;
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      nRun++; nFail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset values
    check("R11 startReady", int'(startReady), 1);
    check("R11 dispReady", int'(dispReady), 0);
    check("R11 doneValid", int'(doneValid), 0);
    rstN = 1'b1;
    // full sweep of mod x rm with changing registers
    for (int md = 0; md < 4; md++) begin
      for (int r = 0; r < 8; r++) begin
        regBx = 16'h1000 + 16'(r * 3); regBp = 16'h2200 + 16'(md);
        regSi = 16'h0030; regDi = 16'h0405;
        runOp({2'(md), 3'b000, 3'(r)}, 1'b0, 3'd0, 1'b0, 8'h9C, 8'h12, 1'b0);
      end
    end
    // overrides meeting bp-default forms, with gaps in the byte stream
    for (int r = 0; r < 8; r++)
      runOp({2'd1, 3'b010, 3'(r)}, 1'b1, 3'(r % 6), 1'b0, 8'h7F, 8'h00, 1'b1);
    // wrap-around (R7) and negative disp8 (R5)
    regBx = 16'hFFF0; regBp = 16'hFFFF; regSi = 16'h0020; regDi = 16'h8000;
    runOp(8'b10_000_000, 1'b0, 3'd0, 1'b0, 8'hF0, 8'hFF, 1'b1);
    runOp(8'b01_000_011, 1'b0, 3'd0, 1'b0, 8'h80, 8'h00, 1'b0);
    runOp(8'b00_000_110, 1'b0, 3'd0, 1'b0, 8'h34, 8'hAB, 1'b1);
    // R10: write fault combinations, including with invalid mod 3
    runOp(8'b00_010_111, 1'b1, 3'd1, 1'b1, 8'h00, 8'h00, 1'b0);
    runOp(8'b00_010_111, 1'b1, 3'd1, 1'b0, 8'h00, 8'h00, 1'b0);
    runOp(8'b00_000_111, 1'b1, 3'd1, 1'b1, 8'h00, 8'h00, 1'b0);
    runOp(8'b00_010_111, 1'b1, 3'd3, 1'b1, 8'h00, 8'h00, 1'b0);
    runOp(8'b11_010_110, 1'b1, 3'd1, 1'b1, 8'h55, 8'h66, 1'b0);
    runOp(8'b11_000_010, 1'b0, 3'd0, 1'b0, 8'h55, 8'h66, 1'b1);
    repeat (3) @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule